// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer with Float Disable

This block watches a software heartbeat line and raises a one-cycle expiry strobe for the reset generator when the line has gone quiet for too long. Either direction of change on the heartbeat counts as proof of life. The timeout is a parameterized number of prescaled ticks, so real timeouts of a second or more reach the counter without a wide register.

A transition that arrives between two ticks is not lost. An edge-capture latch records it until the next tick consumes it. This lets the heartbeat carry pulses as short as one clock even when the tick period is much longer.

Two inputs stop the timer outright. While the system reset is active, the prescaler and counter are held at zero. When an external comparator reports that the heartbeat pin is floating, the watchdog is disabled in the same way. Once either input releases, timing restarts from zero.

Top module: `wdt_strobe_monitor`

## Requirements
- R1: While `rst` is high, `wd_expire` is low, and the tick phase and quiet counter are zero.
- R2: With `wd_strobe` held constant, `wd_expire` goes high exactly `TICK_DIV*TIMEOUT_TICKS` clock edges after the first edge at which both `sys_reset_active` and `strobe_float` are low.
- R3: A rising or falling transition on `wd_strobe` seen at any edge of a tick window restarts the timeout. The counter is zero after that window's tick, and the next expiry needs a further `TIMEOUT_TICKS` quiet ticks.
- R4: A high pulse of a single clock that starts and ends between two ticks still counts as activity at the next tick.
- R5: `wd_expire` is high for exactly one cycle. The counter is zero afterwards, so a further expiry needs another full timeout of quiet strobe.
- R6: While `sys_reset_active` is high, `wd_expire` stays low and no time accumulates. After release, the timeout is measured afresh from zero.
- R7: While `strobe_float` is high, `wd_expire` never asserts, however long the strobe is static. When the flag drops, the timeout restarts from zero.
- R8: The counter advances at most once per `TICK_DIV` clocks, on a tick that occurs every `TICK_DIV`-th edge after hold release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| wd_strobe | input | 1 | Heartbeat line, already synchronized to `clk` |
| strobe_float | input | 1 | High when the heartbeat pin is detected as floating |
| sys_reset_active | input | 1 | High while the system reset output is asserted |
| wd_expire | output | 1 | One-cycle pulse when the timeout elapses |

## Verification
The assertions assume that `wd_strobe`, `strobe_float` and `sys_reset_active` are synchronous to `clk` and settle well before each rising edge. The bench keeps to this by changing every input only on the falling edge. It holds the heartbeat constant through each hold period, so that the first edge after release sees no stale transition unless one is intended. Random runs mix short and long quiet gaps, single-clock pulses, float windows and reset bursts.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Control bundle passed from the front end to the counter
    typedef struct packed {
        logic hold;   // system reset or floating pin
        logic tick;   // prescaler period boundary
        logic seen;   // activity pending for this tick
    } wd_ctl_t;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_HOLD  = 3'd1,
        OP_CLEAR = 3'd2,
        OP_STEP  = 3'd3,
        OP_FIRE  = 3'd4
    } wd_op_e;

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic wd_op_e pick_op(input wd_ctl_t c, input logic at_last);
        if (c.hold)       return OP_HOLD;
        else if (!c.tick) return OP_IDLE;
        else if (c.seen)  return OP_CLEAR;
        else if (at_last) return OP_FIRE;
        else              return OP_STEP;
    endfunction

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int unsigned TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    output logic tick_o
);
    localparam int unsigned PW = wdt_pkg::width_of(TICK_DIV);

    generate
        if (TICK_DIV > 1) begin : g_div
            localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (rst || hold_i)          pre_q <= '0;
                else if (pre_q == PRE_LAST) pre_q <= '0;
                else                        pre_q <= pre_q + 1'b1;
            end

            assign tick_o = !hold_i && (pre_q == PRE_LAST);

            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o) else $error("tick repeated"); // R8
        end else begin : g_nodiv
            logic unused_ok;
            assign unused_ok = clk ^ rst;
            assign tick_o = !hold_i;
        end
    endgenerate

endmodule

// File: rtl/wdt_edge_catch.sv
module wdt_edge_catch (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    input  logic hold_i,
    input  logic tick_i,
    output logic seen_o
);
    logic last_q;
    logic act_q;
    logic edge_now;

    assign edge_now = strobe_i ^ last_q;

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= strobe_i;
    end

    // latch any edge until the next tick consumes it
    always_ff @(posedge clk) begin
        if (rst || hold_i || tick_i) act_q <= 1'b0;
        else if (edge_now)           act_q <= 1'b1;
    end

    assign seen_o = act_q | edge_now;

    AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (edge_now && !tick_i && !hold_i) |=> seen_o) else $error("edge lost"); // R4

endmodule

// File: rtl/wdt_quiet_count.sv
module wdt_quiet_count
    import wdt_pkg::*;
#(
    parameter int unsigned TIMEOUT_TICKS = 10
) (
    input  logic    clk,
    input  logic    rst,
    input  wd_ctl_t ctl_i,
    output logic    expire_o
);
    localparam int unsigned CW = width_of(TIMEOUT_TICKS);
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          exp_q;
    wd_op_e        op;

    always_comb op = pick_op(ctl_i, cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= (op == OP_FIRE);
            case (op)
                OP_HOLD, OP_CLEAR, OP_FIRE: cnt_q <= '0;
                OP_STEP:                    cnt_q <= cnt_q + 1'b1;
                default:                    cnt_q <= cnt_q;
            endcase
        end
    end

    assign expire_o = exp_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LAST) else $error("count overflow"); // R2
    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ctl_i.hold |=> (cnt_q == '0) && !exp_q) else $error("hold leak"); // R6
    AST_SEEN_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.tick && ctl_i.seen && !ctl_i.hold) |=> (cnt_q == '0) && !exp_q)
        else $error("activity ignored"); // R3

endmodule

// File: rtl/wdt_strobe_monitor.sv
module wdt_strobe_monitor
    import wdt_pkg::*;
#(
    parameter int unsigned TICK_DIV      = 4,
    parameter int unsigned TIMEOUT_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic wd_strobe,
    input  logic strobe_float,
    input  logic sys_reset_active,
    output logic wd_expire
);
    wd_ctl_t ctl;
    logic    tick;
    logic    seen;
    logic    hold;

    assign hold = sys_reset_active | strobe_float;

    wdt_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst(rst), .hold_i(hold), .tick_o(tick)
    );

    wdt_edge_catch u_edge (
        .clk(clk), .rst(rst), .strobe_i(wd_strobe),
        .hold_i(hold), .tick_i(tick), .seen_o(seen)
    );

    always_comb begin
        ctl.hold = hold;
        ctl.tick = tick;
        ctl.seen = seen;
    end

    wdt_quiet_count #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_cnt (
        .clk(clk), .rst(rst), .ctl_i(ctl), .expire_o(wd_expire)
    );

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        wd_expire |=> !wd_expire) else $error("expiry too long"); // R5
    AST_SYSRST_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        sys_reset_active |=> !wd_expire) else $error("expiry in reset"); // R6
    AST_FLOAT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        strobe_float |=> !wd_expire) else $error("expiry while floating"); // R7

endmodule

// File: tb/sim_wdt_strobe_monitor.sv
module sim_wdt_strobe_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;
    localparam int TMO = 10;
    localparam int FULL = DIV * TMO;

    logic clk = 1'b0;
    logic rst, strobe, flt, srst;
    logic expire;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    // reference model state
    int   m_pre, m_cnt;
    bit   m_act, m_last, m_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_strobe_monitor #(.TICK_DIV(DIV), .TIMEOUT_TICKS(TMO)) u0 (
        .clk(clk), .rst(rst), .wd_strobe(strobe), .strobe_float(flt),
        .sys_reset_active(srst), .wd_expire(expire)
    );

    task automatic check(input bit act, input bit exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: wd_expire=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // model built from R1..R8: quantized ticks, latched activity, hold clears
    always @(posedge clk) begin
        bit e, t;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_act = 0; m_last = 0; m_exp = 0;
        end else begin
            e = (strobe != m_last);
            m_last = strobe;
            if (srst || flt) begin
                m_pre = 0; m_cnt = 0; m_act = 0; m_exp = 0;
            end else begin
                t = (m_pre == DIV - 1);
                m_pre = t ? 0 : m_pre + 1;
                m_exp = 0;
                if (t) begin
                    if (m_act || e) m_cnt = 0;
                    else if (m_cnt == TMO - 1) begin m_cnt = 0; m_exp = 1; end
                    else m_cnt++;
                    m_act = 0;
                end else if (e) m_act = 1;
            end
        end
    end

    always @(negedge clk) if (!done) check(expire, m_exp, "model R2/R3/R4/R5/R6/R7/R8");

    // n edges after release; expiry expected at edges a and b only
    task automatic run_expect(input int len, input int a, input int b, input string tag);
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            check(expire, (k == a) || (k == b), tag);
        end
    endtask

    task automatic rehold(input int n);
        srst = 1'b1;
        repeat (n) @(negedge clk);
        srst = 1'b0;
    endtask

    task automatic finish_up;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, got 1 expected 0");
        finish_up();
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; srst = 1'b1; flt = 1'b0; strobe = 1'b0;
        repeat (5) begin @(negedge clk); check(expire, 1'b0, "R1 reset state"); end
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R2 + R5: static strobe, expiry at FULL and again at 2*FULL
        srst = 1'b0;
        run_expect(2*FULL + 10, FULL, 2*FULL, "R2/R5 static timeout");

        // R4: one-clock pulse at edge 9 (window start), next tick clears
        rehold(2);
        for (int k = 1; k <= FULL + 20; k++) begin
            if (k == 9)  strobe = 1'b1;
            if (k == 10) strobe = 1'b0;
            @(negedge clk);
            check(expire, k == FULL + 12, "R4 short pulse between ticks");
        end

        // R3: falling transition late in a window
        rehold(2);
        strobe = 1'b1;
        rehold(2);
        for (int k = 1; k <= FULL + 30; k++) begin
            if (k == 19) strobe = 1'b0;
            @(negedge clk);
            check(expire, k == FULL + 20, "R3 falling edge restarts");
        end

        // R6: system reset mid-count restarts from zero
        rehold(2);
        run_expect(30, 0, 0, "R6 before reset");
        rehold(5);
        run_expect(FULL + 5, FULL, 0, "R6 restart after reset");

        // R7: floating pin blocks expiry, restart on release
        flt = 1'b1;
        run_expect(5*FULL, 0, 0, "R7 floating no expiry");
        flt = 1'b0;
        run_expect(FULL + 5, FULL, 0, "R7 restart after float");

        // random mix, checked by the model every cycle (R3 R4 R6 R7 R8)
        for (int i = 0; i < 80; i++) begin
            int sel = $urandom_range(0, 9);
            int gap = $urandom_range(1, 60);
            if (sel == 0)      begin flt = 1'b1; repeat (gap) @(negedge clk); flt = 1'b0; end
            else if (sel == 1) begin srst = 1'b1; repeat ($urandom_range(1, 4)) @(negedge clk); srst = 1'b0; end
            else if (sel == 2) begin strobe = ~strobe; @(negedge clk); strobe = ~strobe; end
            else               strobe = ~strobe;
            repeat (gap) @(negedge clk);
        end
        flt = 1'b0; srst = 1'b0;
        repeat (2*FULL) @(negedge clk);
        finish_up();
    end
endmodule